// File: doc/BRIEF.md
# Paged Serial Flash Range Erase Engine

This block erases a byte range on a paged serial flash. The range is given as a start address and a length in bytes, and both must be whole multiples of the page size. The engine talks to the flash through a byte-wide SPI master port and does not shift bits itself. For each erase step it sends one 4-byte erase command. It then reads the flash status register, waiting a programmable number of cycles between reads, until the device reports ready. After that it moves on to the next step. At each step it uses a fast 8-page block erase when the current page sits on an 8-page boundary and at least 8 pages remain. Otherwise it erases one page.

The page size (it need not be a power of two) and the shift that turns a page index into a device address are configuration inputs. Two bit-serial dividers turn the byte start address and the byte length into a page index and a page count. The division remainders give the alignment check. The caller pulses `start`, sees `busy` for the length of the run, and gets a one-cycle `done` pulse. `error` is valid in that same cycle.

Top module: `flash_erase_seq`

## Requirements
- R1: A request is rejected with `done` and `error` high together, and no flash frame is sent, in any of these cases: the start address is not a whole multiple of `cfg_page_size`, the length is not a whole multiple of it, or it is zero.
- R2: When the current page index has its low three bits at zero and at least 8 pages remain, the engine sends a block erase with opcode 0x50 and then advances the page index by 8 and the remaining count by 8.
- R3: In every other erase step the engine sends a page erase with opcode 0x81 and advances by one page.
- R4: An erase frame is exactly 4 bytes sent while `spi_cs_n` is low: the opcode, then bits 23:16 of (page index << `cfg_page_shift`), then bits 15:8 of it, then 0x00.
- R5: A status read is a 2-byte frame: 0xD7, then 0x00. The byte received during the second byte is the status. Bit 7 of the status set means ready.
- R6: The run finishes with `done` and no error when the remaining page count reaches zero. A zero length finishes without sending any frame.
- R7: Before every status read, `spi_cs_n` stays high for at least `cfg_poll_gap`+1 cycles.
- R8: If `cfg_poll_limit` consecutive status reads after one erase command all return not-ready, the run ends with `done` and `error`, and no further frame is sent.
- R9: `busy` is high from the cycle after an accepted `start` until `done`. `done` is a one-cycle pulse. A `start` that arrives while `busy` is high changes neither the frames sent nor the result.
- R10: After reset, `busy`, `done`, `error` and `spi_tx_valid` are low and `spi_cs_n` is high.
- R11: Only one byte is in flight at a time. `spi_tx_valid` is raised only while `spi_cs_n` is low, and the next byte waits for the `spi_rx_valid` of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted when idle |
| start_addr | input | ADDR_W | Byte address of first page to erase |
| erase_len | input | ADDR_W | Number of bytes to erase |
| cfg_page_size | input | PS_W | Page size in bytes |
| cfg_page_shift | input | SH_W | Left shift from page index to device address |
| cfg_poll_gap | input | GAP_W | Idle cycles added before each status read |
| cfg_poll_limit | input | POLL_W | Not-ready reads allowed per erase command |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Run failed, valid with done |
| spi_cs_n | output | 1 | Chip select, low during a frame |
| spi_tx_valid | output | 1 | Byte offered to the SPI master |
| spi_tx_data | output | 8 | Byte to send |
| spi_tx_ready | input | 1 | SPI master takes the byte |
| spi_rx_valid | input | 1 | Byte exchange finished |
| spi_rx_data | input | 8 | Byte received during the exchange |

## Verification
The main stimulus set covers the following patterns:
- A range that is exactly one aligned block, which must give a single 0x50 frame.
- A range that starts mid-block and spans a boundary, which must give page erases, then a block erase, then a trailing page erase. This separates the boundary test from the remaining-length test.
- Power-of-two and non-power-of-two page sizes with different shifts, and an address above 16 bits. These show that the device address comes from the page index and is not a byte offset.
- Misaligned addresses, misaligned lengths, a zero page size and a zero length. These separate the reject path from the empty-success path.

The flash model holds the device busy for a chosen number of reads. This checks the poll count, the spacing between polls and the timeout. One run gets a second `start` partway through, to show that it is ignored.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_DIV,
        SQ_GAP,
        SQ_CMD,
        SQ_WAIT,
        SQ_POLL
    } seq_state_e;

    typedef enum logic [1:0] {
        XF_IDLE,
        XF_TX,
        XF_RX
    } xfer_state_e;

    localparam logic [7:0] OPC_BLOCK_ERASE = 8'h50;
    localparam logic [7:0] OPC_PAGE_ERASE  = 8'h81;
    localparam logic [7:0] OPC_STATUS      = 8'hD7;
    localparam int         BLOCK_PAGES     = 8;
    localparam int         READY_BIT       = 7;

endpackage

// File: rtl/fes_divider.sv
module fes_divider #(
    parameter int W  = 24,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [W-1:0]  dividend,
    input  logic [DW-1:0] divisor,
    output logic          done,
    output logic [W-1:0]  quotient,
    output logic [DW-1:0] remainder
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          run;
        logic          done;
        logic [CW-1:0] cnt;
        logic [DW:0]   rem;
        logic [W-1:0]  quo;
        logic [DW-1:0] dvs;
    } div_t;

    div_t q, d;
    logic [DW:0] shifted;
    logic        qbit;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        shifted = {q.rem[DW-1:0], q.quo[W-1]};
        qbit    = 1'b0;
        if (start) begin
            d.run = 1'b1;
            d.cnt = '0;
            d.rem = '0;
            d.quo = dividend;
            d.dvs = divisor;
        end else if (q.run) begin
            if (shifted >= {1'b0, q.dvs}) begin
                d.rem = shifted - {1'b0, q.dvs};
                qbit  = 1'b1;
            end else begin
                d.rem = shifted;
            end
            d.quo = {q.quo[W-2:0], qbit};
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == CW'(W - 1)) begin
                d.run  = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done      = q.done;
    assign quotient  = q.quo;
    assign remainder = q.rem[DW-1:0];

    // R1
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.dvs != '0) |-> (q.rem < {1'b0, q.dvs}));

endmodule

// File: rtl/fes_byte_xfer.sv
module fes_byte_xfer
    import flash_erase_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] go_byte,
    output logic       idle,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       tx_ready,
    input  logic       rx_valid,
    input  logic [7:0] rx_data
);
    typedef struct packed {
        xfer_state_e state;
        logic [7:0]  data;
    } xf_t;

    xf_t q, d;

    always_comb begin
        d = q;
        unique case (q.state)
            XF_IDLE: if (go) begin
                d.state = XF_TX;
                d.data  = go_byte;
            end
            XF_TX:   if (tx_ready) d.state = XF_RX;
            XF_RX:   if (rx_valid) d.state = XF_IDLE;
            default: d.state = XF_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: XF_IDLE, data: 8'h00};
        else        q <= d;
    end

    assign idle     = (q.state == XF_IDLE);
    assign tx_valid = (q.state == XF_TX);
    assign tx_data  = q.data;
    assign done     = (q.state == XF_RX) && rx_valid;
    assign rx_byte  = rx_data;

    // R11
    go_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (q.state == XF_IDLE));

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import flash_erase_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int PS_W   = 16,
    parameter int SH_W   = 4,
    parameter int GAP_W  = 16,
    parameter int POLL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] erase_len,
    input  logic [PS_W-1:0]   cfg_page_size,
    input  logic [SH_W-1:0]   cfg_page_shift,
    input  logic [GAP_W-1:0]  cfg_poll_gap,
    input  logic [POLL_W-1:0] cfg_poll_limit,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic              spi_cs_n,
    output logic              spi_tx_valid,
    output logic [7:0]        spi_tx_data,
    input  logic              spi_tx_ready,
    input  logic              spi_rx_valid,
    input  logic [7:0]        spi_rx_data
);
    localparam int DEV_W = ADDR_W + (1 << SH_W);

    typedef struct packed {
        seq_state_e        state;
        logic              zero_ps;
        logic [SH_W-1:0]   shift;
        logic [GAP_W-1:0]  gap;
        logic [POLL_W-1:0] limit;
        logic [ADDR_W-1:0] page_idx;
        logic [ADDR_W-1:0] left;
        logic [1:0]        idx;
        logic              launched;
        logic [GAP_W-1:0]  gap_cnt;
        logic [POLL_W-1:0] poll_cnt;
        logic              done;
        logic              err;
    } seq_t;

    seq_t q, d;

    logic                   div_go;
    logic [1:0]             div_done;
    logic [1:0][ADDR_W-1:0] div_num;
    logic [1:0][ADDR_W-1:0] div_quo;
    logic [1:0][PS_W-1:0]   div_rem;

    logic       x_go, x_idle, x_done;
    logic [7:0] x_byte, x_rx;

    logic [DEV_W-1:0] dev_addr;
    logic             use_block;
    logic [7:0]       opcode;

    assign div_num[0] = start_addr;
    assign div_num[1] = erase_len;

    for (genvar g = 0; g < 2; g++) begin : g_div
        fes_divider #(.W(ADDR_W), .DW(PS_W)) u_div (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (div_go),
            .dividend  (div_num[g]),
            .divisor   (cfg_page_size),
            .done      (div_done[g]),
            .quotient  (div_quo[g]),
            .remainder (div_rem[g])
        );
    end

    fes_byte_xfer u_xfer (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (x_go),
        .go_byte  (x_byte),
        .idle     (x_idle),
        .done     (x_done),
        .rx_byte  (x_rx),
        .tx_valid (spi_tx_valid),
        .tx_data  (spi_tx_data),
        .tx_ready (spi_tx_ready),
        .rx_valid (spi_rx_valid),
        .rx_data  (spi_rx_data)
    );

    assign dev_addr  = DEV_W'(q.page_idx) << q.shift;
    assign use_block = (q.page_idx[2:0] == 3'b000) && (q.left >= ADDR_W'(BLOCK_PAGES));
    assign opcode    = use_block ? OPC_BLOCK_ERASE : OPC_PAGE_ERASE;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        div_go = 1'b0;
        x_go   = 1'b0;
        x_byte = 8'h00;
        unique case (q.state)
            SQ_IDLE: if (start) begin
                d.state   = SQ_DIV;
                d.zero_ps = (cfg_page_size == '0);
                d.shift   = cfg_page_shift;
                d.gap     = cfg_poll_gap;
                d.limit   = cfg_poll_limit;
                div_go    = 1'b1;
            end
            SQ_DIV: if (div_done[0]) begin
                if (q.zero_ps || div_rem[0] != '0 || div_rem[1] != '0) begin
                    d.state = SQ_IDLE;
                    d.done  = 1'b1;
                    d.err   = 1'b1;
                end else if (div_quo[1] == '0) begin
                    d.state = SQ_IDLE;
                    d.done  = 1'b1;
                end else begin
                    d.page_idx = div_quo[0];
                    d.left     = div_quo[1];
                    d.idx      = 2'd0;
                    d.state    = SQ_CMD;
                end
            end
            SQ_GAP: d.state = SQ_CMD;
            SQ_CMD: begin
                unique case (q.idx)
                    2'd0:    x_byte = opcode;
                    2'd1:    x_byte = dev_addr[23:16];
                    2'd2:    x_byte = dev_addr[15:8];
                    default: x_byte = 8'h00;
                endcase
                x_go = !q.launched && x_idle;
                if (x_done) begin
                    if (q.idx == 2'd3) begin
                        d.idx      = 2'd0;
                        d.poll_cnt = '0;
                        d.gap_cnt  = q.gap;
                        d.state    = SQ_WAIT;
                    end else begin
                        d.idx = q.idx + 2'd1;
                    end
                end
            end
            SQ_WAIT: begin
                if (q.gap_cnt == '0) d.state = SQ_POLL;
                else                 d.gap_cnt = q.gap_cnt - 1'b1;
            end
            SQ_POLL: begin
                x_byte = (q.idx == 2'd0) ? OPC_STATUS : 8'h00;
                x_go   = !q.launched && x_idle;
                if (x_done) begin
                    if (q.idx == 2'd0) begin
                        d.idx = 2'd1;
                    end else begin
                        d.idx = 2'd0;
                        if (x_rx[READY_BIT]) begin
                            if (use_block) begin
                                d.page_idx = q.page_idx + ADDR_W'(BLOCK_PAGES);
                                d.left     = q.left - ADDR_W'(BLOCK_PAGES);
                            end else begin
                                d.page_idx = q.page_idx + 1'b1;
                                d.left     = q.left - 1'b1;
                            end
                            if (d.left == '0) begin
                                d.state = SQ_IDLE;
                                d.done  = 1'b1;
                            end else begin
                                d.state = SQ_GAP;
                            end
                        end else if ({1'b0, q.poll_cnt} + 1'b1 >= {1'b0, q.limit}) begin
                            d.state = SQ_IDLE;
                            d.done  = 1'b1;
                            d.err   = 1'b1;
                        end else begin
                            d.poll_cnt = q.poll_cnt + 1'b1;
                            d.gap_cnt  = q.gap;
                            d.state    = SQ_WAIT;
                        end
                    end
                end
            end
            default: d.state = SQ_IDLE;
        endcase
        if (x_go)        d.launched = 1'b1;
        else if (x_done) d.launched = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= SQ_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.state != SQ_IDLE);
    assign done     = q.done;
    assign error    = q.err;
    assign spi_cs_n = !((q.state == SQ_CMD) || (q.state == SQ_POLL));

    // R11
    tx_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_tx_valid |-> !spi_cs_n);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (done && !busy));

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> ($stable(q.shift) && $stable(q.limit)));

    // R8
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == SQ_POLL && q.limit != '0) |-> (q.poll_cnt < q.limit));

endmodule

// File: tb/flash_erase_seq_tb.sv
module flash_erase_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [23:0] addr;
        logic [23:0] len;
        logic [15:0] ps;
        logic [3:0]  sh;
        logic [15:0] gap;
        logic [7:0]  bpolls;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [0:NV-1] = '{
        '{24'd0,       24'd2112, 16'd264,  4'd9,  16'd2, 8'd1},
        '{24'd792,     24'd3696, 16'd264,  4'd9,  16'd0, 8'd0},
        '{24'd100,     24'd264,  16'd264,  4'd9,  16'd0, 8'd0},
        '{24'd528,     24'd265,  16'd264,  4'd9,  16'd0, 8'd0},
        '{24'd1056,    24'd0,    16'd264,  4'd9,  16'd0, 8'd0},
        '{24'd8192,    24'd8192, 16'd512,  4'd10, 16'd3, 8'd2},
        '{24'd1056000, 24'd9504, 16'd1056, 4'd11, 16'd1, 8'd1},
        '{24'd0,       24'd0,    16'd0,    4'd9,  16'd0, 8'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] start_addr = '0, erase_len = '0;
    logic [15:0] cfg_page_size = 16'd264;
    logic [3:0]  cfg_page_shift = 4'd9;
    logic [15:0] cfg_poll_gap = '0, cfg_poll_limit = 16'd50;
    logic        busy, done, error, spi_cs_n, spi_tx_valid;
    logic [7:0]  spi_tx_data;
    logic        spi_rx_valid = 1'b0;
    logic [7:0]  spi_rx_data = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_erase_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .erase_len(erase_len), .cfg_page_size(cfg_page_size),
        .cfg_page_shift(cfg_page_shift), .cfg_poll_gap(cfg_poll_gap),
        .cfg_poll_limit(cfg_poll_limit), .busy(busy), .done(done), .error(error),
        .spi_cs_n(spi_cs_n), .spi_tx_valid(spi_tx_valid), .spi_tx_data(spi_tx_data),
        .spi_tx_ready(1'b1), .spi_rx_valid(spi_rx_valid), .spi_rx_data(spi_rx_data)
    );

    int n_checks = 0, n_fail = 0;

    // flash model and frame log
    int          busy_polls = 0;
    logic [31:0] efr [0:63];
    int          ecount = 0, polls_total = 0, pcount = 0, bad_frames = 0;
    int          hi_cnt = 0, gap_before = 0, min_sgap = 1000000;
    logic [7:0]  fb [0:3];
    int          nb = 0;
    logic        pend = 1'b0, cs_prev = 1'b1;
    logic [7:0]  resp = 8'h00;

    always @(negedge clk) begin
        spi_rx_valid = 1'b0;
        if (pend) begin
            spi_rx_valid = 1'b1;
            spi_rx_data  = resp;
            pend = 1'b0;
        end
        if (spi_tx_valid) begin
            if (nb < 4) fb[nb] = spi_tx_data;
            resp = (nb == 1 && fb[0] == 8'hD7) ?
                   ((pcount >= busy_polls) ? 8'h80 : 8'h00) : 8'hFF;
            nb++;
            pend = 1'b1;
        end
        if (!spi_cs_n && cs_prev) begin
            gap_before = hi_cnt;
            hi_cnt = 0;
        end
        if (spi_cs_n && !cs_prev) begin
            if (nb == 4 && (fb[0] == 8'h50 || fb[0] == 8'h81)) begin
                if (ecount < 64) efr[ecount] = {fb[0], fb[1], fb[2], fb[3]};
                ecount++;
                pcount = 0;
            end else if (nb == 2 && fb[0] == 8'hD7 && fb[1] == 8'h00) begin
                pcount++;
                polls_total++;
                if (gap_before < min_sgap) min_sgap = gap_before;
            end else begin
                bad_frames++;
            end
            nb = 0;
        end
        if (spi_cs_n) hi_cnt++;
        cs_prev = spi_cs_n;
    end

    // expected frames from the requirements
    logic [31:0] exp_fr [0:63];
    int          exp_n;
    bit          exp_err;

    task automatic build_exp(input int addr, input int len, input int ps, input int sh);
        int p, n, da;
        bit blk;
        exp_n = 0;
        exp_err = 0;
        if (ps == 0 || (addr % ps) != 0 || (len % ps) != 0) begin
            exp_err = 1;
            return;
        end
        p = addr / ps;
        n = len / ps;
        while (n > 0) begin
            blk = (p % 8 == 0) && (n >= 8);
            da  = p << sh;
            exp_fr[exp_n] = {blk ? 8'h50 : 8'h81, da[23:16], da[15:8], 8'h00};
            exp_n++;
            if (blk) begin p += 8; n -= 8; end
            else     begin p += 1; n -= 1; end
        end
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic clear_log();
        @(negedge clk);
        ecount = 0; polls_total = 0; pcount = 0; bad_frames = 0;
        min_sgap = 1000000;
    endtask

    bit got_err;

    task automatic run_case(input vec_t v, input int limit, input bit poke);
        int waited;
        clear_log();
        busy_polls     = int'(v.bpolls);
        start_addr     = v.addr;
        erase_len      = v.len;
        cfg_page_size  = v.ps;
        cfg_page_shift = v.sh;
        cfg_poll_gap   = v.gap;
        cfg_poll_limit = 16'(limit);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9", "busy after start", busy, 1);
        waited = 0;
        while (!done && waited < 5000) begin
            if (poke && waited == 60) begin
                start_addr = 24'd0; erase_len = 24'd2112; cfg_page_shift = 4'd3;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            waited++;
        end
        start = 1'b0;
        chk(done == 1'b1, "R9", "done within limit", done, 1);
        got_err = error;
        chk(busy == 1'b0, "R9", "busy low with done", busy, 0);
        @(negedge clk);
        chk(done == 1'b0, "R9", "done one cycle", done, 0);
    endtask

    task automatic check_frames(input vec_t v);
        chk(got_err == exp_err, exp_err ? "R1" : "R6", "error flag", got_err, exp_err);
        chk(ecount == exp_n, "R6", "erase frame count", ecount, exp_n);
        for (int i = 0; i < exp_n && i < ecount; i++)
            chk(efr[i] == exp_fr[i], (exp_fr[i][31:24] == 8'h50) ? "R2" : "R3",
                "erase frame R4 bytes", efr[i], exp_fr[i]);
        chk(bad_frames == 0, "R4", "malformed frames", bad_frames, 0);
        chk(polls_total == exp_n * (int'(v.bpolls) + 1), "R5", "status reads",
            polls_total, exp_n * (int'(v.bpolls) + 1));
        if (polls_total > 0)
            chk(min_sgap >= int'(v.gap) + 1, "R7", "cs high before poll",
                min_sgap, int'(v.gap) + 1);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_fail++;
        $display("FAIL R9 watchdog: actual 0 expected 1");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(busy == 0 && done == 0 && error == 0, "R10", "outputs in reset",
            {busy, done, error}, 0);
        chk(spi_cs_n == 1 && spi_tx_valid == 0, "R10", "spi idle in reset",
            {spi_cs_n, spi_tx_valid}, 2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && spi_cs_n == 1, "R10", "idle after reset", {busy, spi_cs_n}, 1);

        for (int k = 0; k < NV; k++) begin
            build_exp(int'(VECS[k].addr), int'(VECS[k].len), int'(VECS[k].ps), int'(VECS[k].sh));
            run_case(VECS[k], 50, 1'b0);
            check_frames(VECS[k]);
        end

        // R9: start while busy is ignored
        build_exp(int'(VECS[1].addr), int'(VECS[1].len), int'(VECS[1].ps), int'(VECS[1].sh));
        run_case(VECS[1], 50, 1'b1);
        check_frames(VECS[1]);
        repeat (40) @(negedge clk);
        chk(busy == 0 && ecount == exp_n, "R9", "no run from ignored start", ecount, exp_n);

        // R8: timeout after poll limit
        begin
            vec_t tv;
            tv = '{24'd264, 24'd264, 16'd264, 4'd9, 16'd1, 8'd100};
            run_case(tv, 5, 1'b0);
            chk(got_err == 1'b1, "R8", "timeout error", got_err, 1);
            chk(ecount == 1, "R8", "single erase frame", ecount, 1);
            chk(polls_total == 5, "R8", "reads before timeout", polls_total, 5);
            repeat (30) @(negedge clk);
            chk(ecount == 1 && polls_total == 5, "R8", "nothing after timeout",
                polls_total, 5);
        end

        finish_up();
    end
endmodule